// File: doc/BRIEF.md
# Masked-Access General-Purpose I/O Port

This block is one general-purpose I/O port of up to eight pins, with the pin count set by a parameter so that 8-, 6- and 5-pin ports come from the same source. Four registers control the port: pin data, pin direction, alternate-function select and pull-up enable. Software reaches them over a simple word-addressed read/write bus.

The data register is not at a single address. It sits behind a 256-word window, and byte-address bits 9..2 of each access act as a per-pin mask. A store changes only the pins whose mask bit is set. A load returns zero for every pin whose mask bit is clear. One bus store can therefore set or clear chosen pins without a read-modify-write sequence, and no other agent's pins are disturbed.

Each pin drives a pad with three signals: the output value, the output enable and the pull-up enable. A pin whose alternate-select bit is set takes its value and enable from an attached peripheral instead of from the port logic.

Top module: `maskport_top`

## Requirements
- R1: After a synchronous active-low reset, the data, direction, alternate-select and pull-up registers are all zero. Every pin is then a port-controlled input, with `pad_oe`, `pad_pu` and `pad_out` all zero.
- R2: A write to byte address 0x000..0x3FC (bits 11:10 = 00) changes the data register only at the pins whose bit is set in address bits 9..2. Address bit 2+b is the mask for pin b, so offset 0x044 selects pins 4 and 0. Every other data bit keeps its old value.
- R3: A read in the data window returns zero for every pin whose mask bit is clear. Offset 0x000 always reads zero.
- R4: For a pin whose direction bit is 0 (input), the data-window read returns the pin level through a two-flop synchroniser. A change on `pin_in` before clock edge k first shows in the read value after edge k+1.
- R5: For a pin whose direction bit is 1 (output), the data-window read returns the data register bit.
- R6: Bits at positions PINS and above are absent. They read as zero in every register, and writes to them have no effect.
- R7: The direction register is at byte offset 0x400, and bit b set makes pin b an output. When pin b is not handed to the peripheral, `pad_oe[b]` equals this bit and `pad_out[b]` equals the data bit.
- R8: The alternate-select register is at byte offset 0x404. When bit b is set, `pad_out[b]` follows `alt_out[b]` and `pad_oe[b]` follows `alt_oe[b]`.
- R9: The pull-up register is at byte offset 0x408. `pad_pu[b]` equals bit b whatever the alternate-select setting.
- R10: All configuration registers read back the value last written to their implemented bits. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read access |
| pin_in | input | PINS | Pad input levels (asynchronous) |
| alt_out | input | PINS | Output value from the alternate peripheral |
| alt_oe | input | PINS | Output enable from the alternate peripheral |
| pad_out | output | PINS | Pad output value |
| pad_oe | output | PINS | Pad output enable |
| pad_pu | output | PINS | Pad pull-up enable |

## Verification
Register writes take effect at the clock edge that samples the access. The pad outputs and read-back therefore change one edge after a write strobe, and the bench samples them at the next falling edge. Reads are combinational, so the bench samples `bus_rdata` shortly after it drives the address, in the same low phase. Input pins go through two flops. The bench changes `pin_in` on a falling edge, expects the old level after one rising edge and the new level after the second, and so pins the synchroniser depth to exactly two.

// File: rtl/maskport_pkg.sv
// Shared constants and types for the masked-access GPIO port.
// Assumes a 12-bit byte address space per port instance.
package maskport_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int MASK_W = 8;
    localparam int MAX_PINS = 8;

    // Config register select, decoded from byte address bits 3:2 of the config page.
    typedef enum logic [1:0] {
        CFG_DIR  = 2'd0,
        CFG_ALT  = 2'd1,
        CFG_PULL = 2'd2,
        CFG_NONE = 2'd3
    } cfg_sel_e;

    // Result of address decoding for one bus access.
    typedef struct packed {
        logic              win_hit;
        logic              cfg_hit;
        cfg_sel_e          cfg;
        logic [MASK_W-1:0] mask;
    } dec_t;
endpackage

// File: rtl/maskport_decode.sv
// Address decoder. Page 0 (bits 11:10 = 00) is the masked data window, with
// address bits 9:2 as the pin mask. Page 1 (bits 11:10 = 01) holds the config
// registers at word offsets 0..2; everything else is unmapped.
// Assumes byte addresses with bits 1:0 ignored.
module maskport_decode
    import maskport_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [1:0] PAGE_WIN = 2'b00;
    localparam logic [1:0] PAGE_CFG = 2'b01;

    // Split the address into window mask or config selection.
    always_comb begin
        dec         = '0;
        dec.cfg     = CFG_NONE;
        dec.mask    = addr[9:2];
        dec.win_hit = (addr[11:10] == PAGE_WIN);
        if (addr[11:10] == PAGE_CFG && addr[9:4] == '0 &&
            addr[3:2] != 2'd3) begin
            dec.cfg_hit = 1'b1;
            dec.cfg     = cfg_sel_e'(addr[3:2]);
        end
    end
endmodule

// File: rtl/maskport_regs.sv
// Register bank: data, direction, alternate-select and pull-up.
// The data register is written through a per-pin mask. Config registers are
// written whole. Only PINS bits exist, so upper write data bits are dropped.
// Assumes at most one register is written per cycle.
module maskport_regs
    import maskport_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] wdata,
    output logic [PINS-1:0]   data_q,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   alt_q,
    output logic [PINS-1:0]   pull_q
);
    logic [PINS-1:0] pin_mask;
    logic [PINS-1:0] wbits;
    logic            win_wr;

    assign pin_mask = dec.mask[PINS-1:0];
    assign wbits    = wdata[PINS-1:0];
    assign win_wr   = wr_en && dec.win_hit;

    // Masked update of the data register; unmasked pins hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (win_wr) data_q <= (data_q & ~pin_mask) | (wbits & pin_mask);
    end

    // Whole-register update of the three config registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            alt_q  <= '0;
            pull_q <= '0;
        end else if (wr_en && dec.cfg_hit) begin
            case (dec.cfg)
                CFG_DIR:  dir_q  <= wbits;
                CFG_ALT:  alt_q  <= wbits;
                CFG_PULL: pull_q <= wbits;
                default:  ;
            endcase
        end
    end

    // R2: pins outside the mask keep their previous value.
    a_r2_keep_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr |=> (((data_q ^ $past(data_q)) & ~$past(pin_mask)) == '0));

    // R2: pins inside the mask take the written value.
    a_r2_take_masked: assert property (@(posedge clk) disable iff (!rst_n)
        win_wr |=> ((data_q & $past(pin_mask)) == ($past(wbits) & $past(pin_mask))));
endmodule

// File: rtl/maskport_sync.sv
// Multi-stage synchroniser for asynchronous pad inputs, one chain per pin.
// It has no reset: the chains only carry the pin level and settle within
// STAGES clocks.
module maskport_sync #(
    parameter int PINS   = 8,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic [PINS-1:0] async_in,
    output logic [PINS-1:0] sync_out
);
    logic [STAGES-1:0][PINS-1:0] chain;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage captures the raw pad level.
            always_ff @(posedge clk) chain[0] <= async_in;
        end else begin : g_next
            // Later stages shift the captured level along.
            always_ff @(posedge clk) chain[s] <= chain[s-1];
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/maskport_padmux.sv
// Per-pin pad multiplexer. Pins with the alternate bit set are driven by the
// peripheral; the rest are driven by the port's data and direction.
// Pull-up always comes from the port register.
module maskport_padmux #(
    parameter int PINS = 8
) (
    input  logic [PINS-1:0] data_q,
    input  logic [PINS-1:0] dir_q,
    input  logic [PINS-1:0] alt_q,
    input  logic [PINS-1:0] pull_q,
    input  logic [PINS-1:0] alt_out,
    input  logic [PINS-1:0] alt_oe,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic [PINS-1:0] pad_pu
);
    for (genvar b = 0; b < PINS; b++) begin : g_pin
        // Select the owner of pin b.
        always_comb begin
            pad_out[b] = alt_q[b] ? alt_out[b] : data_q[b];
            pad_oe[b]  = alt_q[b] ? alt_oe[b]  : dir_q[b];
            pad_pu[b]  = pull_q[b];
        end
    end
endmodule

// File: rtl/maskport_top.sv
// GPIO port of PINS pins (1..8) with a masked data window.
// Reads are combinational and are driven only while bus_sel is high and
// bus_wr is low. Writes take effect at the sampling clock edge.
// Assumes the bus holds each access for one cycle.
module maskport_top
    import maskport_pkg::*;
#(
    parameter int PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    input  logic [PINS-1:0]   alt_out,
    input  logic [PINS-1:0]   alt_oe,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_pu
);
    localparam int SYNC_STAGES = 2;

    dec_t            dec;
    logic [PINS-1:0] data_q, dir_q, alt_q, pull_q, pin_sync;
    logic [PINS-1:0] win_val;
    logic            wr_en, rd_en;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    maskport_decode u_dec (.addr(bus_addr), .dec(dec));

    maskport_regs #(.PINS(PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .dec(dec), .wdata(bus_wdata),
        .data_q(data_q), .dir_q(dir_q), .alt_q(alt_q), .pull_q(pull_q)
    );

    maskport_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .async_in(pin_in), .sync_out(pin_sync)
    );

    maskport_padmux #(.PINS(PINS)) u_mux (
        .data_q(data_q), .dir_q(dir_q), .alt_q(alt_q), .pull_q(pull_q),
        .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // Outputs read the data register; inputs read the synchronised pin.
    assign win_val = ((dir_q & data_q) | (~dir_q & pin_sync)) & dec.mask[PINS-1:0];

    // Read-back multiplexer; absent bits and unmapped addresses give zero.
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (dec.win_hit) begin
                bus_rdata[PINS-1:0] = win_val;
            end else if (dec.cfg_hit) begin
                case (dec.cfg)
                    CFG_DIR:  bus_rdata[PINS-1:0] = dir_q;
                    CFG_ALT:  bus_rdata[PINS-1:0] = alt_q;
                    CFG_PULL: bus_rdata[PINS-1:0] = pull_q;
                    default:  bus_rdata = '0;
                endcase
            end
        end
    end

    // Cycles-since-reset counter, so that the synchroniser check never reaches before reset.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)              warm <= '0;
        else if (warm != 2'd3)   warm <= warm + 2'd1;
    end

    // R4: an input-pin read shows the pin level from two edges earlier.
    a_r4_two_flop: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && rd_en && dec.win_hit) |->
        (((bus_rdata[PINS-1:0] ^ $past(pin_in, 2)) & ~dir_q & dec.mask[PINS-1:0]) == '0));

    // R7: a direction write shows on pad_oe for port-owned pins.
    a_r7_dir_to_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec.cfg_hit && dec.cfg == CFG_DIR) |=>
        (((pad_oe ^ $past(bus_wdata[PINS-1:0])) & ~alt_q) == '0));

    // R9: a pull-up write shows on pad_pu whatever the alternate select.
    a_r9_pull_to_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec.cfg_hit && dec.cfg == CFG_PULL) |=>
        (pad_pu == $past(bus_wdata[PINS-1:0])));

    // R6: read data above the implemented pins is always zero.
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (bus_rdata[31:PINS] == '0));
endmodule

// File: tb/sim_maskport_top.sv
module sim_maskport_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel0 = 1'b0, sel1 = 1'b0, wr = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd0, rd1;
    logic [7:0]  pin0 = '0, aout0 = '0, aoe0 = '0;
    logic [7:0]  pout0, poe0, ppu0;
    logic [4:0]  pin1 = '0, aout1 = '0, aoe1 = '0;
    logic [4:0]  pout1, poe1, ppu1;
    int          n_chk = 0, n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    maskport_top #(.PINS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel0), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd0), .pin_in(pin0), .alt_out(aout0),
        .alt_oe(aoe0), .pad_out(pout0), .pad_oe(poe0), .pad_pu(ppu0)
    );

    maskport_top #(.PINS(5)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel1), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd1), .pin_in(pin1), .alt_out(aout1),
        .alt_oe(aoe1), .pad_out(pout1), .pad_oe(poe1), .pad_pu(ppu1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bw(input bit u, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        sel0 = !u; sel1 = u; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel0 = 1'b0; sel1 = 1'b0; wr = 1'b0;
    endtask

    task automatic br(input bit u, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        sel0 = !u; sel1 = u; wr = 1'b0; addr = a;
        #1;
        d = u ? rd1 : rd0;
        sel0 = 1'b0; sel1 = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        br(0, 12'h400, v); chk("R1 dir", v, 0);
        br(0, 12'h404, v); chk("R1 alt", v, 0);
        br(0, 12'h408, v); chk("R1 pull", v, 0);
        chk("R1 pad_oe", {24'h0, poe0}, 0);
        chk("R1 pad_pu", {24'h0, ppu0}, 0);
        chk("R1 pad_out", {24'h0, pout0}, 0);
    endtask

    task automatic t_config();
        logic [31:0] v;
        bw(0, 12'h400, 32'hFFFF_FFFF);
        br(0, 12'h400, v); chk("R10 dir readback", v, 32'hFF);
        chk("R7 pad_oe", {24'h0, poe0}, 32'hFF);
        br(0, 12'h40C, v); chk("R10 unmapped", v, 0);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        bw(0, 12'h3FC, 32'hA5);
        br(0, 12'h3FC, v); chk("R5 full read", v, 32'hA5);
        bw(0, 12'h044, 32'hFF);
        br(0, 12'h3FC, v); chk("R2 set pins 4,0", v, 32'hB5);
        bw(0, 12'h044, 32'h00);
        br(0, 12'h3FC, v); chk("R2 clear pins 4,0", v, 32'hA4);
        chk("R7 pad_out", {24'h0, pout0}, 32'hA4);
        br(0, 12'h0F0, v); chk("R3 mask 0x3C", v, 32'h24);
        br(0, 12'h000, v); chk("R3 empty mask", v, 0);
    endtask

    task automatic t_input();
        logic [31:0] v;
        bw(0, 12'h400, 32'h0F);
        @(negedge clk); pin0 = 8'h50;
        br(0, 12'h3FC, v); chk("R4 one edge: old level", v, 32'h04);
        br(0, 12'h3FC, v); chk("R4 two edges: new level", v, 32'h54);
        br(0, 12'h3C0, v); chk("R4 inputs only masked", v, 32'h50);
    endtask

    task automatic t_alt();
        aout0 = 8'h02; aoe0 = 8'h01;
        bw(0, 12'h404, 32'h03);
        chk("R8 pad_out mix", {24'h0, pout0}, 32'hA6);
        chk("R8 pad_oe mix", {24'h0, poe0}, 32'h0D);
        bw(0, 12'h408, 32'h81);
        chk("R9 pad_pu", {24'h0, ppu0}, 32'h81);
        aout0 = 8'h01;
        @(negedge clk);
        chk("R8 follows alt_out", {24'h0, pout0}, 32'hA5);
    endtask

    task automatic t_narrow();
        logic [31:0] v;
        bw(1, 12'h400, 32'hFF);
        br(1, 12'h400, v); chk("R6 dir 5 pins", v, 32'h1F);
        bw(1, 12'h3FC, 32'hFF);
        br(1, 12'h3FC, v); chk("R6 data 5 pins", v, 32'h1F);
        bw(1, 12'h200, 32'h00);
        br(1, 12'h3FC, v); chk("R6 absent pin write ignored", v, 32'h1F);
        chk("R6 pad_out 5 pins", {27'h0, pout1}, 32'h1F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config();
        t_masked();
        t_input();
        t_alt();
        t_narrow();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule